// File: doc/BRIEF.md
# Track-Cut Trigger Decision Unit

This block turns a per-event stream of fitted track words into one accept/reject decision for the trigger supervisor. Every track word carries a fit chi-square, a signed impact parameter and a signed curvature. Each field is compared against a cut loaded before the run. The tracks that pass all three cuts are counted. When the end-of-event word arrives, it carries the event's reduced first-level trigger bits. The event is accepted when enough tracks passed and at least one trigger bit chosen by a selection mask is set.

Every consumed word is echoed on an output stream one cycle later. The echoed word is tagged with its own accept flag: the per-track result for a track word, the event result for the end-of-event word. The event decision is also presented on a valid/acknowledge pair. The input stalls until the supervisor takes the decision. Two saturating scalers count all events and accepted events. A simple write port loads the cuts and clears the scalers.

Top module: `trk_cut_decider`

## Requirements
- R1: A track word packs chi-square in `trk_data[VAL_W-1:0]` (unsigned), impact parameter in `trk_data[2*VAL_W-1:VAL_W]` and curvature in `trk_data[3*VAL_W-1:2*VAL_W]` (both two's complement). A track passes when chi-square <= the chi-square cut, |impact| <= the impact cut and |curvature| <= the curvature cut. The cuts are unsigned, and the magnitude of the most negative value is represented exactly.
- R2: A word is consumed on a clock edge where `trk_valid` and `trk_ready` are both high. One cycle after a track word is consumed, `out_valid`=1, `out_eoe`=0, `out_data` equals the consumed word and `out_pass` is that track's pass result. In a cycle that follows no consumed word, `out_valid`=0.
- R3: The number of passing tracks in the current event saturates at 2^CNT_W-1 (15 by default) and does not wrap.
- R4: An end-of-event word (`trk_eoe`=1) carries the trigger bits in `trk_data[L1W-1:0]`. The event is accepted exactly when the passing count >= the minimum-track setting AND (trigger bits & selection mask) != 0.
- R5: One cycle after an end-of-event word is consumed, `out_valid`=1, `out_eoe`=1 and `out_pass` equals the event decision. The track count then restarts at zero for the next event.
- R6: One cycle after an end-of-event word is consumed, `dec_valid`=1 and `dec_bit` carries the decision. Both hold until a cycle with `dec_ack`=1. While `dec_valid` is high, `trk_ready`=0 and offered words are neither consumed nor counted.
- R7: `scl_total` increments once per event and `scl_accept` once per accepted event, on the same edge that raises `dec_valid`. Both stick at all-ones instead of wrapping.
- R8: A write with `cfg_we`=1 loads a setting by `cfg_addr`: 0 chi-square cut, 1 impact cut, 2 curvature cut, 3 minimum tracks (low CNT_W bits), 4 selection mask (low L1W bits). Address 5 clears both scalers, and the clear wins over a simultaneous increment.
- R9: After reset, `trk_ready`=1, `out_valid`=0, `dec_valid`=0, both scalers read 0, and all settings are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 3 | Setting select |
| cfg_wdata | input | VAL_W | Setting value |
| trk_valid | input | 1 | Input word offered |
| trk_ready | output | 1 | Input word can be consumed |
| trk_eoe | input | 1 | Offered word is the end-of-event word |
| trk_data | input | 3*VAL_W | Track fields or trigger bits |
| out_valid | output | 1 | Echoed word present |
| out_eoe | output | 1 | Echoed word is end-of-event |
| out_pass | output | 1 | Per-track or per-event accept flag |
| out_data | output | 3*VAL_W | Echoed word |
| dec_valid | output | 1 | Event decision pending |
| dec_bit | output | 1 | Event accept decision |
| dec_ack | input | 1 | Supervisor takes the decision |
| scl_total | output | SCL_W | Saturating event scaler |
| scl_accept | output | SCL_W | Saturating accepted-event scaler |

## Verification
The assertions assume the supervisor acknowledges only a pending decision. They also assume that settings are written between events, not inside one. Under these assumptions the decision stays stable and the accepted scaler never exceeds the total scaler. The stimulus writes settings only while no event is open, apart from one deliberate clear that coincides with an end-of-event word. It raises `dec_ack` only while `dec_valid` is high, and offers words during a pending decision only to check that they are refused. A reduced configuration (5-bit fields, 4-bit scalers) lets the bench sweep every field value against several cuts and reach scaler saturation within each run.

// File: rtl/trk_cut_pkg.sv
package trk_cut_pkg;

   typedef enum logic [2:0] {
      CA_CHI    = 3'd0,
      CA_IMP    = 3'd1,
      CA_CURV   = 3'd2,
      CA_MINTRK = 3'd3,
      CA_MASK   = 3'd4,
      CA_CLR    = 3'd5
   } cfg_addr_e;

   localparam int unsigned NUM_FIELDS = 3;

endpackage

// File: rtl/trk_cut_cfg.sv
module trk_cut_cfg
   import trk_cut_pkg::*;
#(
   parameter int unsigned VAL_W = 12,
   parameter int unsigned CNT_W = 4,
   parameter int unsigned L1W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_addr,
   input  logic [VAL_W-1:0] cfg_wdata,
   output logic [VAL_W-1:0] chi_max,
   output logic [VAL_W-1:0] imp_max,
   output logic [VAL_W-1:0] cv_max,
   output logic [CNT_W-1:0] min_trk,
   output logic [L1W-1:0]   sel_mask,
   output logic             scl_clr
);

   if (CNT_W > VAL_W || L1W > VAL_W) begin : g_bad_width
      $error("trk_cut_cfg: CNT_W and L1W must not exceed VAL_W");
   end

   assign scl_clr = cfg_we && (cfg_addr == CA_CLR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chi_max  <= '0;
         imp_max  <= '0;
         cv_max   <= '0;
         min_trk  <= '0;
         sel_mask <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            CA_CHI:    chi_max  <= cfg_wdata;
            CA_IMP:    imp_max  <= cfg_wdata;
            CA_CURV:   cv_max   <= cfg_wdata;
            CA_MINTRK: min_trk  <= cfg_wdata[CNT_W-1:0];
            CA_MASK:   sel_mask <= cfg_wdata[L1W-1:0];
            default:   ;
         endcase
      end
   end

endmodule

// File: rtl/trk_cut_eval.sv
module trk_cut_eval
   import trk_cut_pkg::*;
#(
   parameter int unsigned VAL_W = 12,
   localparam int unsigned WORD_W = NUM_FIELDS * VAL_W
) (
   input  logic [WORD_W-1:0] word,
   input  logic [VAL_W-1:0]  chi_max,
   input  logic [VAL_W-1:0]  imp_max,
   input  logic [VAL_W-1:0]  cv_max,
   output logic              pass
);

   if (VAL_W < 2) begin : g_bad_val
      $error("trk_cut_eval: VAL_W must be at least 2");
   end

   logic [NUM_FIELDS-1:0][VAL_W-1:0] lim;
   logic [NUM_FIELDS-1:0]            ok;

   assign lim = {cv_max, imp_max, chi_max};

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
      logic [VAL_W-1:0] fld;
      assign fld = word[g*VAL_W +: VAL_W];
      if (g == 0) begin : g_unsigned
         assign ok[g] = (fld <= lim[g]);
      end else begin : g_signed
         logic [VAL_W:0] ext;
         logic [VAL_W:0] mag;
         assign ext   = {fld[VAL_W-1], fld};
         assign mag   = ext[VAL_W] ? (~ext + 1'b1) : ext;
         assign ok[g] = (mag <= {1'b0, lim[g]});
      end
   end

   assign pass = &ok;

endmodule

// File: rtl/trk_cut_event.sv
module trk_cut_event #(
   parameter int unsigned WORD_W = 36,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned L1W    = 2,
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_eoe,
   input  logic [WORD_W-1:0] in_data,
   input  logic              trk_pass,
   input  logic [CNT_W-1:0]  min_trk,
   input  logic [L1W-1:0]    sel_mask,
   output logic              in_ready,
   output logic              out_valid,
   output logic              out_eoe,
   output logic              out_pass,
   output logic [WORD_W-1:0] out_data,
   output logic              dec_valid,
   output logic              dec_bit,
   input  logic              dec_ack,
   output logic              evt_done,
   output logic              evt_acc
);

   if (L1W > WORD_W) begin : g_bad_l1
      $error("trk_cut_event: L1W exceeds word width");
   end

   logic [CNT_W-1:0] npass;
   logic             take;
   logic             l1_hit;

   assign in_ready = !dec_valid;
   assign take     = in_valid && in_ready;
   assign l1_hit   = |(in_data[L1W-1:0] & sel_mask);
   assign evt_acc  = (npass >= min_trk) && l1_hit;
   assign evt_done = take && in_eoe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         npass     <= '0;
         dec_valid <= 1'b0;
         dec_bit   <= 1'b0;
         out_valid <= 1'b0;
         out_eoe   <= 1'b0;
         out_pass  <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= take;
         if (take) begin
            out_eoe  <= in_eoe;
            out_pass <= in_eoe ? evt_acc : trk_pass;
            out_data <= in_data;
         end
         if (evt_done) begin
            npass     <= '0;
            dec_valid <= 1'b1;
            dec_bit   <= evt_acc;
         end else begin
            if (take && trk_pass && (npass != CNT_MAX))
               npass <= npass + 1'b1;
            if (dec_valid && dec_ack)
               dec_valid <= 1'b0;
         end
      end
   end

   assert_count_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (npass == CNT_MAX && take && !in_eoe) |=> (npass == CNT_MAX));

   assert_decision_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_ack) |=> (dec_valid && $stable(dec_bit)));

   assert_decision_from_eoe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dec_valid) |-> $past(in_valid && in_eoe));

   assert_eoe_echo_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_eoe) |-> (dec_valid && (out_pass == dec_bit)));

endmodule

// File: rtl/trk_cut_scaler.sv
module trk_cut_scaler #(
   parameter int unsigned SCL_W = 32,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [SCL_W-1:0] count
);

   if (SCL_W < 2) begin : g_bad_w
      $error("trk_cut_scaler: SCL_W must be at least 2");
   end

   logic [SCL_W-1:0] nxt;

   if (SATURATE) begin : g_sat
      assign nxt = (&count) ? count : count + 1'b1;

      assert_scaler_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !clr |=> (count >= $past(count)));
   end else begin : g_wrap
      assign nxt = count + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      count <= '0;
      else if (clr)    count <= '0;
      else if (inc)    count <= nxt;
   end

   assert_scaler_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));

endmodule

// File: rtl/trk_cut_decider.sv
module trk_cut_decider
   import trk_cut_pkg::*;
#(
   parameter int unsigned VAL_W = 12,
   parameter int unsigned CNT_W = 4,
   parameter int unsigned L1W   = 2,
   parameter int unsigned SCL_W = 32,
   localparam int unsigned WORD_W = NUM_FIELDS * VAL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [VAL_W-1:0]  cfg_wdata,
   input  logic              trk_valid,
   output logic              trk_ready,
   input  logic              trk_eoe,
   input  logic [WORD_W-1:0] trk_data,
   output logic              out_valid,
   output logic              out_eoe,
   output logic              out_pass,
   output logic [WORD_W-1:0] out_data,
   output logic              dec_valid,
   output logic              dec_bit,
   input  logic              dec_ack,
   output logic [SCL_W-1:0]  scl_total,
   output logic [SCL_W-1:0]  scl_accept
);

   logic [VAL_W-1:0] chi_max, imp_max, cv_max;
   logic [CNT_W-1:0] min_trk;
   logic [L1W-1:0]   sel_mask;
   logic             scl_clr;
   logic             trk_pass;
   logic             evt_done, evt_acc;

   trk_cut_cfg #(.VAL_W(VAL_W), .CNT_W(CNT_W), .L1W(L1W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .chi_max   (chi_max),
      .imp_max   (imp_max),
      .cv_max    (cv_max),
      .min_trk   (min_trk),
      .sel_mask  (sel_mask),
      .scl_clr   (scl_clr)
   );

   trk_cut_eval #(.VAL_W(VAL_W)) u_eval (
      .word    (trk_data),
      .chi_max (chi_max),
      .imp_max (imp_max),
      .cv_max  (cv_max),
      .pass    (trk_pass)
   );

   trk_cut_event #(.WORD_W(WORD_W), .CNT_W(CNT_W), .L1W(L1W)) u_event (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (trk_valid),
      .in_eoe    (trk_eoe),
      .in_data   (trk_data),
      .trk_pass  (trk_pass),
      .min_trk   (min_trk),
      .sel_mask  (sel_mask),
      .in_ready  (trk_ready),
      .out_valid (out_valid),
      .out_eoe   (out_eoe),
      .out_pass  (out_pass),
      .out_data  (out_data),
      .dec_valid (dec_valid),
      .dec_bit   (dec_bit),
      .dec_ack   (dec_ack),
      .evt_done  (evt_done),
      .evt_acc   (evt_acc)
   );

   trk_cut_scaler #(.SCL_W(SCL_W), .SATURATE(1'b1)) u_scl_total (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (scl_clr),
      .inc   (evt_done),
      .count (scl_total)
   );

   trk_cut_scaler #(.SCL_W(SCL_W), .SATURATE(1'b1)) u_scl_accept (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (scl_clr),
      .inc   (evt_done && evt_acc),
      .count (scl_accept)
   );

   assert_accept_le_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
      scl_accept <= scl_total);

   assert_stall_while_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !dec_ack) |=> !out_valid);

endmodule

// File: tb/tb_trk_cut_decider.sv
module tb_trk_cut_decider;

   localparam int VW = 5;
   localparam int CW = 4;
   localparam int LW = 2;
   localparam int SW = 4;
   localparam int WW = 3 * VW;
   localparam int SMAX = (1 << SW) - 1;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [VW-1:0] cfg_wdata = '0;
   logic          trk_valid = 1'b0;
   logic          trk_ready;
   logic          trk_eoe = 1'b0;
   logic [WW-1:0] trk_data = '0;
   logic          out_valid, out_eoe, out_pass;
   logic [WW-1:0] out_data;
   logic          dec_valid, dec_bit;
   logic          dec_ack = 1'b0;
   logic [SW-1:0] scl_total, scl_accept;

   int n_chk = 0;
   int n_fail = 0;
   int m_tot = 0;
   int m_acc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   trk_cut_decider #(.VAL_W(VW), .CNT_W(CW), .L1W(LW), .SCL_W(SW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .trk_valid(trk_valid), .trk_ready(trk_ready),
      .trk_eoe(trk_eoe), .trk_data(trk_data), .out_valid(out_valid),
      .out_eoe(out_eoe), .out_pass(out_pass), .out_data(out_data),
      .dec_valid(dec_valid), .dec_bit(dec_bit), .dec_ack(dec_ack),
      .scl_total(scl_total), .scl_accept(scl_accept)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int sval(input int v);
      return (v >= (1 << (VW - 1))) ? v - (1 << VW) : v;
   endfunction

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic int sat(input int v);
      return (v >= SMAX) ? SMAX : v + 1;
   endfunction

   task automatic cfg_write(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = VW'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_scalers();
      cfg_write(5, 0);
      m_tot = 0; m_acc = 0;
      check("R8 clear total", int'(scl_total), 0);
      check("R8 clear accept", int'(scl_accept), 0);
   endtask

   // sends one track word and checks its echo (R1, R2)
   task automatic send_track(input int chi, input int imp, input int cv, input int exp_pass);
      logic [WW-1:0] w;
      w = {VW'(cv), VW'(imp), VW'(chi)};
      @(negedge clk);
      trk_valid = 1'b1; trk_eoe = 1'b0; trk_data = w;
      @(negedge clk);
      trk_valid = 1'b0;
      check("R2 out_valid", int'(out_valid), 1);
      check("R2 out_eoe", int'(out_eoe), 0);
      check("R2 out_data", int'(out_data), int'(w));
      check("R1 track pass", int'(out_pass), exp_pass);
   endtask

   task automatic ack();
      @(negedge clk);
      dec_ack = 1'b1;
      @(negedge clk);
      dec_ack = 1'b0;
      check("R6 dec_valid drops after ack", int'(dec_valid), 0);
      check("R6 ready after ack", int'(trk_ready), 1);
   endtask

   // sends the end-of-event word, checks decision, scalers and handshake (R4-R7)
   task automatic end_event(input int l1, input int exp_acc);
      @(negedge clk);
      trk_valid = 1'b1; trk_eoe = 1'b1; trk_data = WW'(l1);
      @(negedge clk);
      trk_valid = 1'b0; trk_eoe = 1'b0;
      m_tot = sat(m_tot);
      if (exp_acc != 0) m_acc = sat(m_acc);
      check("R5 eoe echo valid", int'(out_valid), 1);
      check("R5 eoe echo flag", int'(out_eoe), 1);
      check("R4 event accept", int'(out_pass), exp_acc);
      check("R6 dec_valid", int'(dec_valid), 1);
      check("R6 dec_bit", int'(dec_bit), exp_acc);
      check("R6 stalled ready", int'(trk_ready), 0);
      check("R7 total scaler", int'(scl_total), m_tot);
      check("R7 accept scaler", int'(scl_accept), m_acc);
      ack();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 ready", int'(trk_ready), 1);
      check("R9 out_valid", int'(out_valid), 0);
      check("R9 dec_valid", int'(dec_valid), 0);
      check("R9 total", int'(scl_total), 0);
      check("R9 accept", int'(scl_accept), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: settings are zero, so only an all-zero track passes
      send_track(0, 0, 0, 1);
      send_track(1, 0, 0, 0);
      send_track(0, 31, 0, 0);
      end_event(3, 0);

      // R1 sweep of each field against three cut sets; mask 0 forces reject (R4)
      for (int s = 0; s < 3; s++) begin
         int cmax, imax, vmax;
         cmax = (s == 0) ? 0 : (s == 1) ? 7 : 31;
         imax = (s == 0) ? 5 : (s == 1) ? 15 : 16;
         vmax = (s == 0) ? 16 : (s == 1) ? 0 : 3;
         cfg_write(0, cmax);
         cfg_write(1, imax);
         cfg_write(2, vmax);
         cfg_write(3, 0);
         cfg_write(4, 0);
         for (int v = 0; v < 32; v++) begin
            send_track(v, 0, 0, (v <= cmax) ? 1 : 0);
            send_track(0, v, 0, (iabs(sval(v)) <= imax) ? 1 : 0);
            send_track(0, 0, v, (iabs(sval(v)) <= vmax) ? 1 : 0);
         end
         end_event(3, 0);
      end

      // R3/R4/R7 event sweep: all tracks pass
      cfg_write(0, 31); cfg_write(1, 31); cfg_write(2, 31);
      for (int mi = 0; mi < 4; mi++) begin
         int mv;
         mv = (mi == 0) ? 0 : (mi == 1) ? 1 : (mi == 2) ? 3 : 15;
         cfg_write(3, mv);
         for (int mk = 0; mk < 4; mk++) begin
            cfg_write(4, mk);
            clear_scalers();
            for (int n = 0; n < 18; n++) begin
               for (int l1 = 0; l1 < 4; l1++) begin
                  int cnt, e;
                  for (int t = 0; t < n; t++) send_track(t & 7, 0, 0, 1);
                  cnt = (n > CMAX) ? CMAX : n;
                  e = ((cnt >= mv) && ((l1 & mk) != 0)) ? 1 : 0;
                  end_event(l1, e);
               end
            end
         end
      end

      // R6 stall: words offered while a decision is pending are refused
      cfg_write(3, 1); cfg_write(4, 3);
      end_event(1, 0);
      send_track(0, 0, 0, 1);
      @(negedge clk);
      trk_valid = 1'b1; trk_eoe = 1'b1; trk_data = WW'(1);
      @(negedge clk);
      trk_valid = 1'b1; trk_eoe = 1'b0; trk_data = '0;
      m_tot = sat(m_tot); m_acc = sat(m_acc);
      check("R6 pending decision", int'(dec_valid), 1);
      check("R6 pending accept bit", int'(dec_bit), 1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R6 ready low while pending", int'(trk_ready), 0);
         check("R6 no echo while stalled", int'(out_valid), 0);
         check("R6 decision held", int'(dec_bit), 1);
      end
      trk_valid = 1'b0;
      ack();
      // stalled tracks were not counted: count 0 < min 1
      end_event(1, 0);

      // R8: clear wins over a simultaneous increment
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = '0;
      trk_valid = 1'b1; trk_eoe = 1'b1; trk_data = WW'(1);
      @(negedge clk);
      cfg_we = 1'b0; trk_valid = 1'b0; trk_eoe = 1'b0;
      m_tot = 0; m_acc = 0;
      check("R8 clear beats increment total", int'(scl_total), 0);
      check("R8 clear beats increment accept", int'(scl_accept), 0);
      check("R5 eoe echo with clear", int'(out_eoe), 1);
      ack();
      // R8: unused address changes nothing
      cfg_write(6, 0);
      send_track(0, 0, 0, 1);
      end_event(2, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule